// File: doc/BRIEF.md
# Three-Phase Current Sum Accumulator

This block gathers motor phase current samples between two host readouts. Each time the converter front end delivers a fresh set of samples, one for each phase, the block adds every sample to a per-phase running sum. It also counts how many sets have been summed. The host can then divide each sum by the count and get an average current over a window of any length, instead of seeing one instantaneous value.

When a host transfer completes, a single strobe copies the sums and the count into output registers. In the same clock cycle it restarts the accumulators, so the next window begins at once. A sample set that arrives in that same cycle is counted once, as the first entry of the new window. The sums and the count saturate rather than wrap. A window that runs too long therefore reports a pinned maximum and never a small wrong number.

Top module: `phase_current_accum`

## Requirements
- R1: After reset, every sum output and the count output are zero, and the first window starts empty.
- R2: On each cycle with `smp_valid` high, the 12-bit value in bits [12k+11:12k] of `smp_data` is added to the running sum of phase k+1 (k = 0, 1, 2). Phase 1 therefore takes bits [11:0].
- R3: Each cycle with `smp_valid` high adds exactly one to the window's set count.
- R4: A cycle with `xfer_done` high loads the window's sums and count into the outputs. The new values are visible from the next clock cycle.
- R5: After `xfer_done`, the new window starts from zero sums and a zero count. A transfer with no samples since the previous one reports all zeros.
- R6: A sample set that is valid in the same cycle as `xfer_done` is left out of the reported window and becomes the first entry of the new window.
- R7: The outputs keep their values on every cycle in which `xfer_done` is low, whatever happens on the sample inputs.
- R8: Each phase sum saturates at 2^24-1 (16777215) and never wraps.
- R9: The set count saturates at 255 and never wraps.
- R10: The sum for phase k+1 appears on bits [24k+23:24k] of `sum_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A complete three-phase sample set is present on `smp_data` |
| smp_data | input | 36 | Packed samples; phase k+1 at bits [12k+11:12k] |
| xfer_done | input | 1 | Host transfer complete; close the window and restart |
| sum_out | output | 72 | Reported sums; phase k+1 at bits [24k+23:24k] |
| set_count | output | 8 | Number of sample sets in the reported sums |

## Verification
A wrong accumulator or count register stays hidden at the ports until the next transfer strobe. It then shows up in the cycle after that strobe as one wrong sum or count. The bench therefore closes many windows of different lengths, including empty ones and back-to-back strobes, so that every window's contents reach the outputs. Between strobes the outputs are compared on every cycle. A window long enough to pin both saturating fields shows whether an overflow wraps.

// File: rtl/pca_pkg.sv
package pca_pkg;
    localparam int unsigned PCA_PHASES   = 3;
    localparam int unsigned PCA_SAMPLE_W = 12;
    localparam int unsigned PCA_SUM_W    = 24;
    localparam int unsigned PCA_CNT_W    = 8;
endpackage

// File: rtl/pca_lane.sv
module pca_lane #(
    parameter int unsigned SAMPLE_W = pca_pkg::PCA_SAMPLE_W,
    parameter int unsigned SUM_W    = pca_pkg::PCA_SUM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_en,
    input  logic                restart,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    snap_q
);
    localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] snap;
    } lane_t;

    lane_t st_d, st_q;
    logic [SUM_W:0] wide_sum;

    always_comb begin
        st_d     = st_q;
        wide_sum = {1'b0, st_q.acc} + {{(SUM_W+1-SAMPLE_W){1'b0}}, sample};
        if (restart) begin
            st_d.snap = st_q.acc;
            st_d.acc  = add_en ? {{(SUM_W-SAMPLE_W){1'b0}}, sample} : '0;
        end else if (add_en) begin
            st_d.acc = wide_sum[SUM_W] ? SUM_MAX : wide_sum[SUM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_q = st_q.snap;

    a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(st_q.snap));
    a_r8_sum_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == SUM_MAX && add_en && !restart) |=> st_q.acc == SUM_MAX);
    a_r2_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> st_q.acc >= $past(st_q.acc));
endmodule

// File: rtl/pca_counter.sv
module pca_counter #(
    parameter int unsigned CNT_W = pca_pkg::PCA_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             restart,
    output logic [CNT_W-1:0] snap_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.snap = st_q.cnt;
            st_d.cnt  = add_en ? CNT_ONE : '0;
        end else if (add_en && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_q = st_q.snap;

    a_r9_count_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && add_en && !restart) |=> st_q.cnt == CNT_MAX);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !restart && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + CNT_ONE);
    a_r5_empty_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !add_en) |=> st_q.cnt == '0);
    a_r6_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && add_en) |=> st_q.cnt == CNT_ONE);
endmodule

// File: rtl/phase_current_accum.sv
module phase_current_accum #(
    parameter int unsigned PHASES   = pca_pkg::PCA_PHASES,
    parameter int unsigned SAMPLE_W = pca_pkg::PCA_SAMPLE_W,
    parameter int unsigned SUM_W    = pca_pkg::PCA_SUM_W,
    parameter int unsigned CNT_W    = pca_pkg::PCA_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [PHASES*SAMPLE_W-1:0] smp_data,
    input  logic                       xfer_done,
    output logic [PHASES*SUM_W-1:0]    sum_out,
    output logic [CNT_W-1:0]           set_count
);
    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_lane
            pca_lane #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .add_en  (smp_valid),
                .restart (xfer_done),
                .sample  (smp_data[p*SAMPLE_W +: SAMPLE_W]),
                .snap_q  (sum_out[p*SUM_W +: SUM_W])
            );
        end
    endgenerate

    pca_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (smp_valid),
        .restart (xfer_done),
        .snap_q  (set_count)
    );

    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(set_count));
    a_r4_empty_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && $past(xfer_done) && !$past(smp_valid)) |=> (set_count == '0 && sum_out == '0));
endmodule

// File: tb/phase_current_accum_bench.sv
module phase_current_accum_bench;
    localparam int SUM_MAX = 16777215;
    localparam int CNT_MAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [35:0] smp_data = '0;
    logic        xfer_done = 1'b0;
    logic [71:0] sum_out;
    logic [7:0]  set_count;

    int checks = 0;
    int errors = 0;
    int acc [3];
    int cnt;
    int exp_sum [3];
    int exp_cnt;

    always #10 clk = ~clk;

    phase_current_accum u_phase_current_accum (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .xfer_done(xfer_done), .sum_out(sum_out), .set_count(set_count)
    );

    task automatic compare(input string tag);
        checks++;
        if (int'(set_count) != exp_cnt) begin
            errors++;
            $display("FAIL %s count actual %0d expected %0d", tag, set_count, exp_cnt);
        end
        for (int p = 0; p < 3; p++) begin
            checks++;
            if (int'(sum_out[p*24 +: 24]) != exp_sum[p]) begin
                errors++;
                $display("FAIL %s phase%0d sum actual %0d expected %0d",
                         tag, p + 1, sum_out[p*24 +: 24], exp_sum[p]);
            end
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic v, input int s0, input int s1, input int s2,
                        input logic d, input string tag);
        int s [3];
        s[0] = s0; s[1] = s1; s[2] = s2;
        smp_valid = v;
        xfer_done = d;
        smp_data  = {s2[11:0], s1[11:0], s0[11:0]};
        @(posedge clk);
        @(negedge clk);
        if (d) begin
            for (int p = 0; p < 3; p++) exp_sum[p] = acc[p];
            exp_cnt = cnt;
            for (int p = 0; p < 3; p++) acc[p] = v ? s[p] : 0;
            cnt = v ? 1 : 0;
        end else if (v) begin
            for (int p = 0; p < 3; p++) acc[p] = (acc[p] + s[p] > SUM_MAX) ? SUM_MAX : acc[p] + s[p];
            cnt = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1;
        end
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens [7];
        lens = '{0, 1, 2, 7, 40, 255, 300};
        for (int p = 0; p < 3; p++) begin acc[p] = 0; exp_sum[p] = 0; end
        cnt = 0; exp_cnt = 0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        // R2 R3 R10: windows of varied length, idle cycles mixed in; R7 checked each cycle
        for (int w = 0; w < 7; w++) begin
            for (int k = 0; k < lens[w]; k++) begin
                step(1'b1, (k*37 + w*5) % 4096, (k*53 + 1111) % 4096, (k*211 + 2222 + w) % 4096,
                     1'b0, "R7 hold during window");
                if (k % 3 == 2) step(1'b0, 4095, 4095, 4095, 1'b0, "R7 idle ignored");
            end
            step(1'b0, 0, 0, 0, 1'b1, "R4 R2 R3 R10 window report");
        end
        // R6: sample with strobe joins new window
        step(1'b1, 100, 200, 300, 1'b0, "R7 pre");
        step(1'b1, 7, 8, 9, 1'b1, "R6 coincident excluded");
        step(1'b0, 0, 0, 0, 1'b1, "R6 coincident first entry");
        // R5: back-to-back strobes report empty
        step(1'b0, 0, 0, 0, 1'b1, "R5 empty window");
        step(1'b0, 0, 0, 0, 1'b1, "R5 empty again");
        // R8 R9: long window pins sums and count
        for (int k = 0; k < 4100; k++)
            step(1'b1, 4095, 1, 2048, 1'b0, "R7 long window");
        step(1'b0, 0, 0, 0, 1'b1, "R8 R9 saturation");
        checks++;
        if (int'(sum_out[23:0]) != SUM_MAX || set_count != 8'd255) begin
            errors++;
            $display("FAIL R8 R9 pinned actual %0d/%0d expected %0d/255",
                     sum_out[23:0], set_count, SUM_MAX);
        end
        step(1'b1, 1, 2, 3, 1'b0, "R5 restart after saturation");
        step(1'b0, 0, 0, 0, 1'b1, "R5 fresh window after saturation");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule